// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a watchdog timer that sits behind a simple 32-bit register port. Software programs a control word that does four things: it turns the timer on, it picks the count source (every bus clock cycle, or only cycles in which an external slow-clock tick is present), it arms an interrupt stage and a reset stage, and it selects the two intervals as powers of two. When the first interval runs out, a sticky status flag is set and drives the interrupt line. A second counter then starts. If software does not restart the timer before that counter ends, the block emits a one-cycle reset request.

Both the control register and the restart register are guarded. A key written to the unlock register opens exactly one following bus write. A restart also needs its own key value. The intent is that a runaway program cannot silently reprogram or feed the watchdog.

Top module: `guard_timer`

## Requirements
- R1: After synchronous reset, the control word and the status flag read as zero, and `irq` and `rst_req` are low.
- R2: A write to the control register (offset 0x10) takes effect only if the bus write just before it put 32'h0000_5AA5 into the unlock register (offset 0x18). Otherwise the write is ignored. The control fields are: bit 0 run, bit 1 count source (1 = every clock, 0 = `ext_tick` cycles), bit 2 interrupt stage on, bit 3 reset stage on, bits [7:4] interrupt code, bits [10:8] reset code.
- R3: An unlock is used up by whatever bus write follows it. A wrong key in the unlock register, or a write to any other register, leaves the next control write locked.
- R4: Writing 32'h0000_CAFE to the restart register (offset 0x14), straight after an unlock, clears the interval counter and cancels a running reset stage. A restart with another value, or with no unlock before it, has no effect.
- R5: The status flag sets on the 2^n-th counted tick after start or restart. For interrupt codes 0..15, n is 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31. `irq` is high while the flag is set and the interrupt stage is on.
- R6: Status is bit 0 at offset 0x1C. Writing 1 clears it, and writing 0 leaves it alone. It is set on expiry even when the interrupt stage is off. It needs no unlock.
- R7: Each expiry starts a second counter if it is not already running. When that counter reaches its interval with no restart in between, `rst_req` is high for exactly one cycle if the reset stage is on. If the reset stage is off, there is no pulse.
- R8: The reset interval is 2^(7+code) counted ticks, where code is control bits [10:8] (2^7 to 2^14).
- R9: Clearing the run bit stops both counters and clears them to zero. A later start counts the full interval again.
- R10: Offset 0x00 reads the `ID_VALUE` constant and ignores writes. The restart and unlock registers read as zero.
- R11: With the count source bit clear, the counters advance only in cycles where `ext_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | One-cycle pulse per slow-clock tick |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt, level |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with the default 32-bit interval counter and overrides `ID_VALUE` with its own constant, so the identity read is checked against a value the bench chose. The small interrupt codes 0 and 1 (64 and 256 ticks) and reset codes 0 and 2 (128 and 512 ticks) keep every expiry and every reset pulse within a few hundred cycles. In the slow-clock run, the bench produces `ext_tick` on every fourth cycle, which puts the stretched expiry in reach as well.

// File: rtl/gt_pkg.sv
package gt_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // register map (byte offsets, decoded in full)
    localparam logic [ADDR_W-1:0] OFS_ID      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RESTART = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_UNLOCK  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h1C;

    localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'h0000_5AA5;
    localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_CAFE;

    localparam int INT_CODE_W = 4;
    localparam int RST_CODE_W = 3;
    localparam int INT_N_MAX  = 31;
    localparam int RST_N_BASE = 7;
    localparam int RST_N_MAX  = RST_N_BASE + (1 << RST_CODE_W) - 1;

    typedef struct packed {
        logic [RST_CODE_W-1:0] rst_code;
        logic [INT_CODE_W-1:0] int_code;
        logic                  rst_on;
        logic                  int_on;
        logic                  bus_clk;
        logic                  run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // interrupt interval exponent: 6, 8, then 10..15, then odd 17..31
    function automatic int unsigned int_exp(logic [INT_CODE_W-1:0] code);
        int unsigned c;
        c = int'(code);
        if (c < 2)      return 6 + 2 * c;
        else if (c < 8) return c + 8;
        else            return 2 * c + 1;
    endfunction

    function automatic int unsigned rst_exp(logic [RST_CODE_W-1:0] code);
        return RST_N_BASE + int'(code);
    endfunction

endpackage

// File: rtl/gt_regs.sv
module gt_regs
    import gt_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic              status,
    output logic              restart,
    output logic              irq
);

    logic unlock;
    logic wr_ctrl;
    logic clr_status;

    assign wr_ctrl    = wr_en && (addr == OFS_CTRL) && unlock;
    assign restart    = wr_en && (addr == OFS_RESTART) && unlock && (wdata == RESTART_KEY);
    assign clr_status = wr_en && (addr == OFS_STATUS) && wdata[0];
    assign irq        = status && ctrl.int_on;

    // one-shot unlock: any bus write replaces it
    always_ff @(posedge clk) begin
        if (rst) begin
            unlock <= 1'b0;
        end else if (wr_en) begin
            unlock <= (addr == OFS_UNLOCK) && (wdata == UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // expiry wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (expire) begin
            status <= 1'b1;
        end else if (clr_status) begin
            status <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_ID:     rdata = ID_VALUE;
            OFS_CTRL:   rdata = DATA_W'(ctrl);
            OFS_STATUS: rdata = DATA_W'(status);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gt_counter.sv
module gt_counter
    import gt_pkg::*;
#(
    parameter int CNT_W = INT_N_MAX + 1,
    parameter int RST_W = RST_N_MAX + 1
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  ext_tick,
    input  logic  restart,
    output logic  expire,
    output logic  rst_pulse
);

    logic [CNT_W-1:0] cnt_main;
    logic [RST_W-1:0] cnt_rst;
    logic             stage2;
    logic             tick;
    logic [CNT_W-1:0] int_lim;
    logic [RST_W-1:0] rst_lim;
    logic             stage2_done;

    always_comb begin
        int_lim = CNT_W'((64'd1 << int_exp(ctrl.int_code)) - 64'd1);
        rst_lim = RST_W'((64'd1 << rst_exp(ctrl.rst_code)) - 64'd1);
    end

    assign tick        = ctrl.run && (ctrl.bus_clk || ext_tick);
    assign expire      = tick && !restart && (cnt_main == int_lim);
    assign stage2_done = tick && stage2 && (cnt_rst == rst_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_main  <= '0;
            cnt_rst   <= '0;
            stage2    <= 1'b0;
            rst_pulse <= 1'b0;
        end else if (!ctrl.run || restart) begin
            cnt_main  <= '0;
            cnt_rst   <= '0;
            stage2    <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= 1'b0;
            if (tick) begin
                cnt_main <= (cnt_main == int_lim) ? '0 : cnt_main + 1'b1;
            end
            if (stage2_done) begin
                stage2    <= 1'b0;
                cnt_rst   <= '0;
                rst_pulse <= ctrl.rst_on;
            end else if (tick && stage2) begin
                cnt_rst <= cnt_rst + 1'b1;
            end else if (expire && !stage2) begin
                stage2  <= 1'b1;
                cnt_rst <= '0;
            end
        end
    end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import gt_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h5744_0200,
    parameter int                CNT_W    = INT_N_MAX + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);

    ctrl_t ctrl;
    logic  status;
    logic  restart;
    logic  expire;

    gt_regs #(.ID_VALUE(ID_VALUE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .expire  (expire),
        .rdata   (rdata),
        .ctrl    (ctrl),
        .status  (status),
        .restart (restart),
        .irq     (irq)
    );

    gt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .ext_tick  (ext_tick),
        .restart   (restart),
        .expire    (expire),
        .rst_pulse (rst_req)
    );

endmodule

// File: rtl/gt_checker.sv
module gt_checker
    import gt_pkg::*;
#(
    parameter int CNT_W = INT_N_MAX + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input ctrl_t             ctrl,
    input logic              status,
    input logic              expire,
    input logic              restart,
    input logic              unlock,
    input logic [CNT_W-1:0]  cnt_main,
    input logic              rst_req
);

    p_lock_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CTRL && !unlock) |=> $stable(ctrl));

    p_consume_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != OFS_UNLOCK) |=> !unlock);

    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_main == '0));

    p_status_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_STATUS && wdata[0] && !expire) |=> !status);

    p_rst_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    p_rst_gate_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(ctrl.rst_on));

    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> (cnt_main == '0));

endmodule

bind guard_timer gt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ctrl     (ctrl),
    .status   (status),
    .expire   (expire),
    .restart  (restart),
    .unlock   (u_regs.unlock),
    .cnt_main (u_cnt.cnt_main),
    .rst_req  (rst_req)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;
    import gt_pkg::*;

    localparam logic [31:0] TB_ID = 32'h1D5E_7A01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_req;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    bit ext_gen = 1'b0;

    typedef struct {
        int    at;
        bit    is_rst;
        logic  val;
        string req;
    } item_t;
    item_t q[$];

    guard_timer #(.ID_VALUE(TB_ID)) i_guard_timer (
        .clk(clk), .rst(rst), .ext_tick(ext_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // slow-clock tick: edge e carries a tick when (e-1) % 4 == 0
    initial forever begin
        @(negedge clk);
        ext_tick = ext_gen && (cyc % 4 == 0);
    end

    // monitor: pop expected output values at their cycle
    initial forever begin
        @(negedge clk);
        while (q.size() > 0 && q[0].at <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.at < cyc) begin
                nchk++;
                nerr++;
                $display("FAIL %s: actual missed expected sample at cycle %0d", it.req, it.at);
            end else begin
                chk(it.req, it.is_rst ? {31'b0, rst_req} : {31'b0, irq}, {31'b0, it.val});
            end
        end
    end

    task automatic push(int at, bit is_rst, logic val, string req);
        item_t it;
        it.at = at; it.is_rst = is_rst; it.val = val; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, output int e);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        e = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pwr(logic [7:0] a, logic [31:0] d, output int e);
        int t;
        wr(OFS_UNLOCK, UNLOCK_KEY, t);
        wr(a, d, e);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        addr = a;
        #1 chk(req, rdata, exp);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic stop_and_clear();
        int e;
        pwr(OFS_CTRL, 32'h0, e);
        wr(OFS_STATUS, 32'h1, e);
        rd(OFS_STATUS, 32'h0, "R6 status cleared by writing 1");
    endtask

    initial begin
        int w, r, e, x, n;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 / R10 reset state and identity
        rd(OFS_ID, TB_ID, "R10 id value");
        rd(OFS_CTRL, 32'h0, "R1 ctrl reset");
        rd(OFS_STATUS, 32'h0, "R1 status reset");
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 rst_req reset", {31'b0, rst_req}, 32'h0);
        wr(OFS_ID, 32'hFFFF_FFFF, e);
        rd(OFS_ID, TB_ID, "R10 id ignores writes");
        rd(OFS_UNLOCK, 32'h0, "R10 unlock reads zero");

        // R2 / R3 lock behaviour
        wr(OFS_CTRL, 32'h00F, e);
        rd(OFS_CTRL, 32'h0, "R2 ctrl write without unlock");
        wr(OFS_UNLOCK, UNLOCK_KEY, e);
        wr(OFS_STATUS, 32'h0, e);
        wr(OFS_CTRL, 32'h00F, e);
        rd(OFS_CTRL, 32'h0, "R3 unlock consumed by other write");
        wr(OFS_UNLOCK, 32'h0000_1234, e);
        wr(OFS_CTRL, 32'h00F, e);
        rd(OFS_CTRL, 32'h0, "R3 wrong unlock key");

        // R5 / R7: code 0 interrupt (64), code 0 reset (128)
        pwr(OFS_CTRL, 32'h00F, w);
        rd(OFS_CTRL, 32'h00F, "R2 unlocked ctrl write");
        push(w + 63, 0, 1'b0, "R5 irq before 2^6");
        push(w + 64, 0, 1'b1, "R5 irq at 2^6");
        push(w + 191, 1, 1'b0, "R7 rst_req before reset interval");
        push(w + 192, 1, 1'b1, "R7 rst_req pulse");
        push(w + 193, 1, 1'b0, "R7 rst_req one cycle");
        wait_until(w + 195);
        rd(OFS_STATUS, 32'h1, "R6 status set on expiry");
        stop_and_clear();
        chk("R6 irq low after clear", {31'b0, irq}, 32'h0);

        // R4 / R8: code 1 interrupt (256), code 2 reset (512), good restart
        pwr(OFS_CTRL, 32'h21F, w);
        wait_until(w + 100);
        pwr(OFS_RESTART, RESTART_KEY, r);
        push(w + 256, 0, 1'b0, "R4 restart delays expiry");
        push(r + 255, 0, 1'b0, "R4 irq before interval after restart");
        push(r + 256, 0, 1'b1, "R4 irq at interval after restart");
        push(r + 256 + 511, 1, 1'b0, "R8 rst_req before 2^9");
        push(r + 256 + 512, 1, 1'b1, "R8 rst_req at 2^9");
        wait_until(r + 256 + 515);
        stop_and_clear();

        // R4 bad restarts ignored; R7 no pulse with reset stage off
        pwr(OFS_CTRL, 32'h017, w);
        wait_until(w + 50);
        wr(OFS_RESTART, RESTART_KEY, e);
        pwr(OFS_RESTART, 32'h0000_CAFF, e);
        push(w + 255, 0, 1'b0, "R4 irq before interval");
        push(w + 256, 0, 1'b1, "R4 bad restarts ignored");
        push(w + 256 + 128, 1, 1'b0, "R7 no pulse with reset stage off");
        wait_until(w + 390);
        stop_and_clear();

        // R5 masked interrupt, R6 status still set
        pwr(OFS_CTRL, 32'h003, w);
        push(w + 64, 0, 1'b0, "R5 irq masked");
        push(w + 100, 0, 1'b0, "R5 irq masked later");
        wait_until(w + 101);
        rd(OFS_STATUS, 32'h1, "R6 status set with interrupt stage off");
        wr(OFS_STATUS, 32'h0, e);
        rd(OFS_STATUS, 32'h1, "R6 writing 0 keeps status");
        pwr(OFS_CTRL, 32'h007, e);
        chk("R5 irq follows status when enabled", {31'b0, irq}, 32'h1);
        stop_and_clear();

        // R9 stopping clears the counter
        pwr(OFS_CTRL, 32'h007, w);
        wait_until(w + 40);
        pwr(OFS_CTRL, 32'h0, e);
        pwr(OFS_CTRL, 32'h007, w);
        push(w + 63, 0, 1'b0, "R9 full interval after stop");
        push(w + 64, 0, 1'b1, "R9 expiry after restart from zero");
        wait_until(w + 66);
        stop_and_clear();

        // R11 slow clock source
        ext_gen = 1'b1;
        pwr(OFS_CTRL, 32'h005, w);
        x = w;
        n = 0;
        while (n < 64) begin
            x++;
            if ((x - 1) % 4 == 0) n++;
        end
        push(x - 1, 0, 1'b0, "R11 irq before 64 slow ticks");
        push(x, 0, 1'b1, "R11 irq at 64 slow ticks");
        wait_until(x + 2);
        stop_and_clear();

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule